// File: doc/BRIEF.md
# Ratio-Coded One-Wire Brightness Command Receiver

This block listens to a single shared control line, already synchronized to the local clock and oversampled by it, and takes in brightness commands. Every bit opens with a falling edge. The bit value comes from comparing how long the line stays low with how long it then stays high, so the sender may pick any bit rate inside a wide span and needs no fixed bit clock. A command is two bytes. The first is a device address. The second holds an acknowledge-request flag, two select bits that must be zero, and a brightness code. When a command is accepted, the code is latched into a register and a one-cycle strobe is raised.

When the request flag is set on an accepted command, the block pulls the line low for a fixed time as an acknowledge. The pull is an open-drain enable: outside the block the line is the wired AND of the sender and this pull-down. A frame that breaks any rule is dropped and the register keeps its value. The register returns to full scale only on reset. A long low on the line, such as a shutdown interval, does not disturb it.

Top module: `ratio_wire_rx`

## Requirements
- R1: After reset `code_o` is DEFAULT_CODE (31), `frame_stb_o` is 0 and `ack_pull_o` is 0.
- R2: A bit runs from one falling edge to the next. It is 1 when its high time is at least twice its low time, and 0 when its low time is at least twice its high time. Bytes are received MSB first.
- R3: A bit that meets neither 2:1 margin aborts the frame, and `code_o` stays unchanged.
- R4: The first falling edge of a frame is taken only if the line was high for at least START_CYC cycles before it. An earlier falling edge is ignored.
- R5: A byte closes when the high phase reaches EOS_CYC cycles. Its final bit is judged with a high time equal to EOS_CYC. A byte closing with a bit count other than 8 aborts, and so does a ninth falling edge inside a byte.
- R6: The first byte must equal DEV_ADDR (0x72). Any other value means no update and no acknowledge.
- R7: In the second byte, bit 7 is the acknowledge request and bits 6:5 must be 00. Bits 4:0 are the code. On acceptance `code_o` takes bits 4:0 and `frame_stb_o` pulses high for exactly one cycle. Nonzero select bits mean no update.
- R8: `ack_pull_o` rises only for an accepted frame with bit 7 set. It rises ACK_DLY+1 cycles after the last falling edge of the frame, or two cycles after that byte closes if that is later. It stays high for exactly ACK_LEN cycles.
- R9: A low phase reaching LOW_MAX_CYC inside a frame aborts it. A wait between the two bytes reaching GAP_MAX_CYC also aborts it. Internal time counters saturate and never wrap.
- R10: `code_o` keeps its value through aborted frames and through long low intervals on the line.
- R11: Decoding gives the same result when all in-byte low and high times are scaled by a common factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Synchronized level of the shared control line |
| code_o | output | CODE_W (5) | Stored brightness code |
| frame_stb_o | output | 1 | One-cycle pulse when a command is accepted |
| ack_pull_o | output | 1 | Open-drain pull-down enable for the acknowledge |

## Verification
The bench builds the block with START_CYC=8, EOS_CYC=40, LOW_MAX_CYC=200, GAP_MAX_CYC=400, ACK_DLY=100 and ACK_LEN=60. These short windows make every timing limit reachable in a few hundred cycles. With them the bench can sweep all 32 codes at three bit-rate scales and flip each of the eight address bits one at a time. They also let it reach both acknowledge timing cases: a last-bit-1 frame, where the delay sets the start, and a last-bit-0 frame, where the byte close sets it. Every abort path is also driven: ratio miss, wrong bit count, long low, long gap and a short start.

// File: rtl/ratio_wire_pkg.sv
package ratio_wire_pkg;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_ADDR,
      FR_DATA,
      FR_ACK
   } frame_state_e;

   typedef enum logic [1:0] {
      AK_OFF,
      AK_WAIT,
      AK_PULL
   } ack_state_e;

   typedef struct packed {
      logic is_one;
      logic is_zero;
   } bit_verdict_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/ratio_wire_phase.sv
module ratio_wire_phase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   output logic             fall_o,
   output logic [CNT_W-1:0] low_cnt_o,
   output logic [CNT_W-1:0] high_cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             prev_q;
   logic             rise;
   logic [CNT_W-1:0] low_q;
   logic [CNT_W-1:0] high_q;

   assign fall_o     = prev_q & ~line_i;
   assign rise       = ~prev_q & line_i;
   assign low_cnt_o  = low_q;
   assign high_cnt_o = high_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         low_q  <= '0;
         high_q <= '0;
      end else begin
         prev_q <= line_i;
         if (!line_i) begin
            if (fall_o)
               low_q <= CNT_ONE;
            else if (low_q != CNT_MAX)
               low_q <= low_q + CNT_ONE;
         end else begin
            if (rise)
               high_q <= CNT_ONE;
            else if (high_q != CNT_MAX)
               high_q <= high_q + CNT_ONE;
         end
      end
   end

   // R9: the low-phase counter holds at its ceiling instead of wrapping
   p_low_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_i && prev_q == 1'b0 && low_q == CNT_MAX) |=> (low_q == CNT_MAX));

   // R9: the high-phase counter holds at its ceiling instead of wrapping
   p_high_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (line_i && prev_q == 1'b1 && high_q == CNT_MAX) |=> (high_q == CNT_MAX));

endmodule

// File: rtl/ratio_wire_judge.sv
module ratio_wire_judge
   import ratio_wire_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int MARGIN_LOG2 = 1
) (
   input  logic [CNT_W-1:0] low_i,
   input  logic [CNT_W-1:0] high_i,
   output bit_verdict_t     verdict_o
);

   localparam int EXT_W = CNT_W + MARGIN_LOG2;

   logic [EXT_W-1:0] low_ext;
   logic [EXT_W-1:0] high_ext;
   logic [EXT_W-1:0] low_scaled;
   logic [EXT_W-1:0] high_scaled;

   generate
      if (MARGIN_LOG2 < 1 || MARGIN_LOG2 > 3) begin : g_bad_margin
         $error("ratio_wire_judge: MARGIN_LOG2 must lie in 1..3");
      end
   endgenerate

   always_comb begin
      low_ext     = EXT_W'(low_i);
      high_ext    = EXT_W'(high_i);
      low_scaled  = low_ext << MARGIN_LOG2;
      high_scaled = high_ext << MARGIN_LOG2;
      verdict_o.is_one  = (low_i != '0) && (high_ext >= low_scaled);
      verdict_o.is_zero = (high_i != '0) && (low_ext >= high_scaled);
   end

endmodule

// File: rtl/ratio_wire_frame.sv
module ratio_wire_frame
   import ratio_wire_pkg::*;
#(
   parameter int          CNT_W        = 16,
   parameter int          CODE_W       = 5,
   parameter logic [7:0]  DEV_ADDR     = 8'h72,
   parameter int          START_CYC    = 8,
   parameter int          EOS_CYC      = 2400,
   parameter int          LOW_MAX_CYC  = 12000,
   parameter int          GAP_MAX_CYC  = 16000,
   parameter int          DEFAULT_CODE = 31,
   parameter bit          ACK_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   input  logic              fall_i,
   input  logic [CNT_W-1:0]  low_cnt_i,
   input  logic [CNT_W-1:0]  high_cnt_i,
   input  bit_verdict_t      verdict_i,
   input  logic              ack_done_i,
   output logic [CODE_W-1:0] code_o,
   output logic              frame_stb_o,
   output logic              ack_req_o,
   output logic              in_ack_o
);

   localparam int              SEL_W    = BYTE_W - 1 - CODE_W;
   localparam int              BCNT_W   = $clog2(BYTE_W + 1);
   localparam logic [BCNT_W-1:0] BCNT_FULL = BCNT_W'(BYTE_W);
   localparam logic [BCNT_W-1:0] BCNT_ONE  = BCNT_W'(1);
   localparam logic [CNT_W-1:0] START_L  = CNT_W'(START_CYC);
   localparam logic [CNT_W-1:0] EOS_L    = CNT_W'(EOS_CYC);
   localparam logic [CNT_W-1:0] LOWMAX_L = CNT_W'(LOW_MAX_CYC);
   localparam logic [CNT_W-1:0] GAP_L    = CNT_W'(GAP_MAX_CYC);

   frame_state_e      st_q, st_d;
   logic [BCNT_W-1:0] cnt_q, cnt_d;
   logic [BYTE_W-1:0] sh_q, sh_d;
   logic [CODE_W-1:0] code_q, code_d;
   logic              stb_q, stb_d;
   logic              areq_q, areq_d;

   logic              eos_evt;
   logic              low_evt;
   logic              gap_evt;
   logic              bit_ok;
   logic              bit_val;
   logic [BYTE_W-1:0] byte_full;
   logic [SEL_W-1:0]  sel_bits;

   generate
      if (SEL_W < 1) begin : g_bad_code_w
         $error("ratio_wire_frame: CODE_W leaves no select bits");
      end
   endgenerate

   assign eos_evt   = line_i && (high_cnt_i == EOS_L);
   assign low_evt   = !line_i && (low_cnt_i == LOWMAX_L);
   assign gap_evt   = line_i && (high_cnt_i == GAP_L);
   assign bit_ok    = verdict_i.is_one | verdict_i.is_zero;
   assign bit_val   = verdict_i.is_one;
   assign byte_full = {sh_q[BYTE_W-2:0], bit_val};
   assign sel_bits  = byte_full[BYTE_W-2 -: SEL_W];

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      sh_d   = sh_q;
      code_d = code_q;
      stb_d  = 1'b0;
      areq_d = 1'b0;
      unique case (st_q)
         FR_IDLE: begin
            if (fall_i && (high_cnt_i >= START_L)) begin
               st_d  = FR_ADDR;
               cnt_d = BCNT_ONE;
            end
         end
         FR_ADDR, FR_DATA: begin
            if (low_evt) begin
               st_d = FR_IDLE;
            end else if (fall_i) begin
               if (cnt_q == '0) begin
                  cnt_d = BCNT_ONE;
               end else if (cnt_q == BCNT_FULL || !bit_ok) begin
                  st_d = FR_IDLE;
               end else begin
                  sh_d  = byte_full;
                  cnt_d = cnt_q + BCNT_ONE;
               end
            end else if (eos_evt && cnt_q != '0) begin
               if (cnt_q != BCNT_FULL || !bit_ok) begin
                  st_d = FR_IDLE;
               end else if (st_q == FR_ADDR) begin
                  if (byte_full == DEV_ADDR) begin
                     st_d  = FR_DATA;
                     cnt_d = '0;
                  end else begin
                     st_d = FR_IDLE;
                  end
               end else if (sel_bits == '0) begin
                  code_d = byte_full[CODE_W-1:0];
                  stb_d  = 1'b1;
                  if (ACK_EN && byte_full[BYTE_W-1]) begin
                     areq_d = 1'b1;
                     st_d   = FR_ACK;
                  end else begin
                     st_d = FR_IDLE;
                  end
               end else begin
                  st_d = FR_IDLE;
               end
            end else if (gap_evt && cnt_q == '0) begin
               st_d = FR_IDLE;
            end
         end
         FR_ACK: begin
            if (ack_done_i)
               st_d = FR_IDLE;
         end
         default: st_d = FR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= FR_IDLE;
         cnt_q  <= '0;
         sh_q   <= '0;
         code_q <= CODE_W'(DEFAULT_CODE);
         stb_q  <= 1'b0;
         areq_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         sh_q   <= sh_d;
         code_q <= code_d;
         stb_q  <= stb_d;
         areq_q <= areq_d;
      end
   end

   assign code_o      = code_q;
   assign frame_stb_o = stb_q;
   assign ack_req_o   = areq_q;
   assign in_ack_o    = (st_q == FR_ACK);

   // R7: the accept strobe lasts a single cycle
   p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |=> !stb_q);

   // R3: the stored code moves only together with an accept strobe
   p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_d |=> $stable(code_q));

   // R5: never more than one byte's worth of bits counted
   p_bitcnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= BCNT_FULL);

endmodule

// File: rtl/ratio_wire_ack.sv
module ratio_wire_ack
   import ratio_wire_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int ACK_DLY = 8,
   parameter int ACK_LEN = 2048
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_i,
   input  logic [CNT_W:0] elapsed_i,
   output logic           pull_o,
   output logic           done_o
);

   localparam int            W     = CNT_W + 1;
   localparam logic [W-1:0]  DLY_L = W'(ACK_DLY);
   localparam logic [W-1:0]  LEN_L = W'(ACK_LEN - 1);
   localparam logic [W-1:0]  ONE_L = W'(1);
   localparam logic [W-1:0]  MAX_L = '1;

   ack_state_e   st_q;
   logic [W-1:0] cnt_q;
   logic         done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= AK_OFF;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            AK_OFF: begin
               if (req_i) begin
                  st_q  <= AK_WAIT;
                  cnt_q <= elapsed_i;
               end
            end
            AK_WAIT: begin
               if (cnt_q >= DLY_L) begin
                  st_q  <= AK_PULL;
                  cnt_q <= '0;
               end else if (cnt_q != MAX_L) begin
                  cnt_q <= cnt_q + ONE_L;
               end
            end
            AK_PULL: begin
               if (cnt_q == LEN_L) begin
                  st_q   <= AK_OFF;
                  cnt_q  <= '0;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + ONE_L;
               end
            end
            default: st_q <= AK_OFF;
         endcase
      end
   end

   assign pull_o = (st_q == AK_PULL);
   assign done_o = done_q;

   // R8: the pull-down never outlasts its programmed length
   p_pull_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pull_o |-> (cnt_q <= LEN_L));

endmodule

// File: rtl/ratio_wire_rx.sv
module ratio_wire_rx
   import ratio_wire_pkg::*;
#(
   parameter int         CNT_W        = 16,
   parameter int         CODE_W       = 5,
   parameter logic [7:0] DEV_ADDR     = 8'h72,
   parameter int         MARGIN_LOG2  = 1,
   parameter int         START_CYC    = 8,
   parameter int         EOS_CYC      = 2400,
   parameter int         LOW_MAX_CYC  = 12000,
   parameter int         GAP_MAX_CYC  = 16000,
   parameter int         ACK_DLY      = 8,
   parameter int         ACK_LEN      = 2048,
   parameter int         DEFAULT_CODE = 31,
   parameter bit         ACK_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output logic [CODE_W-1:0] code_o,
   output logic              frame_stb_o,
   output logic              ack_pull_o
);

   localparam longint CNT_CEIL = (64'd1 << CNT_W) - 1;

   logic             fall;
   logic [CNT_W-1:0] low_cnt;
   logic [CNT_W-1:0] high_cnt;
   logic [CNT_W:0]   elapsed;
   bit_verdict_t     verdict;
   logic             ack_req;
   logic             ack_done;
   logic             in_ack;

   generate
      if (EOS_CYC <= START_CYC) begin : g_bad_eos
         $error("ratio_wire_rx: EOS_CYC must exceed START_CYC");
      end
      if (GAP_MAX_CYC <= EOS_CYC || longint'(GAP_MAX_CYC) >= CNT_CEIL) begin : g_bad_gap
         $error("ratio_wire_rx: GAP_MAX_CYC must lie above EOS_CYC and below the counter ceiling");
      end
      if (longint'(LOW_MAX_CYC) >= CNT_CEIL || LOW_MAX_CYC <= 2 * EOS_CYC) begin : g_bad_low
         $error("ratio_wire_rx: LOW_MAX_CYC must exceed twice EOS_CYC and stay below the ceiling");
      end
      if (ACK_LEN < 1 || DEFAULT_CODE >= (1 << CODE_W)) begin : g_bad_misc
         $error("ratio_wire_rx: ACK_LEN or DEFAULT_CODE out of range");
      end
   endgenerate

   ratio_wire_phase #(
      .CNT_W (CNT_W)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i),
      .fall_o     (fall),
      .low_cnt_o  (low_cnt),
      .high_cnt_o (high_cnt)
   );

   ratio_wire_judge #(
      .CNT_W       (CNT_W),
      .MARGIN_LOG2 (MARGIN_LOG2)
   ) u_judge (
      .low_i     (low_cnt),
      .high_i    (high_cnt),
      .verdict_o (verdict)
   );

   ratio_wire_frame #(
      .CNT_W        (CNT_W),
      .CODE_W       (CODE_W),
      .DEV_ADDR     (DEV_ADDR),
      .START_CYC    (START_CYC),
      .EOS_CYC      (EOS_CYC),
      .LOW_MAX_CYC  (LOW_MAX_CYC),
      .GAP_MAX_CYC  (GAP_MAX_CYC),
      .DEFAULT_CODE (DEFAULT_CODE),
      .ACK_EN       (ACK_EN)
   ) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line_i),
      .fall_i      (fall),
      .low_cnt_i   (low_cnt),
      .high_cnt_i  (high_cnt),
      .verdict_i   (verdict),
      .ack_done_i  (ack_done),
      .code_o      (code_o),
      .frame_stb_o (frame_stb_o),
      .ack_req_o   (ack_req),
      .in_ack_o    (in_ack)
   );

   assign elapsed = {1'b0, low_cnt} + {1'b0, high_cnt};

   generate
      if (ACK_EN) begin : g_ack
         ratio_wire_ack #(
            .CNT_W   (CNT_W),
            .ACK_DLY (ACK_DLY),
            .ACK_LEN (ACK_LEN)
         ) u_ack (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (ack_req),
            .elapsed_i (elapsed),
            .pull_o    (ack_pull_o),
            .done_o    (ack_done)
         );
      end else begin : g_no_ack
         assign ack_pull_o = 1'b0;
         assign ack_done   = 1'b1;
      end
   endgenerate

   // R8: the pull-down only happens while the frame logic waits on an acknowledge
   p_pull_in_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_pull_o |-> in_ack);

   // R7: no command is accepted while the acknowledge owns the line
   p_no_accept_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ack && $past(in_ack)) |-> !frame_stb_o);

endmodule

// File: tb/ratio_wire_rx_bench.sv
module ratio_wire_rx_bench;

   localparam int P_START = 8;
   localparam int P_EOS   = 40;
   localparam int P_LOW   = 200;
   localparam int P_GAP   = 400;
   localparam int P_DLY   = 100;
   localparam int P_LEN   = 60;
   localparam int L1_LAST = 4;
   localparam int L0_LAST = 90;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       drv = 1'b1;
   logic [4:0] code;
   logic       stb;
   logic       pull;
   logic       line;

   always #2 clk = ~clk;

   assign line = drv & ~pull;

   ratio_wire_rx #(
      .START_CYC   (P_START),
      .EOS_CYC     (P_EOS),
      .LOW_MAX_CYC (P_LOW),
      .GAP_MAX_CYC (P_GAP),
      .ACK_DLY     (P_DLY),
      .ACK_LEN     (P_LEN)
   ) u_ratio_wire_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line),
      .code_o      (code),
      .frame_stb_o (stb),
      .ack_pull_o  (pull)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;
   int stb_cnt = 0;
   int pulses  = 0;
   int pull_start = 0;
   int run_len    = 0;
   int last_len   = 0;
   int last_fall  = 0;
   int last_lo    = 0;
   logic pull_prev = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (stb) stb_cnt++;
      if (pull && !pull_prev) begin
         pulses++;
         pull_start = cyc;
         run_len = 0;
      end
      if (pull) run_len++;
      if (!pull && pull_prev) last_len = run_len;
      pull_prev = pull;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      drv = v;
      repeat (n) @(negedge clk);
   endtask

   // in-byte bits: 1 = short low, long high; 0 = long low, short high
   task automatic send_bits(input logic [8:0] val, input int nb, input int s);
      for (int i = nb - 1; i >= 1; i--) begin
         if (val[i]) begin
            hold(1'b0, 5 * s); hold(1'b1, 12 * s);
         end else begin
            hold(1'b0, 12 * s); hold(1'b1, 5 * s);
         end
      end
      last_fall = cyc + 1;
      last_lo   = val[0] ? L1_LAST : L0_LAST;
      hold(1'b0, last_lo);
      hold(1'b1, P_EOS + 5);
   endtask

   task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input int s);
      send_bits({1'b0, a}, 8, s);
      send_bits({1'b0, d}, 8, s);
      hold(1'b1, 250);
   endtask

   task automatic expect_no_change(input string tag, input int sc, input int pc);
      chk(code == 5'd10, {tag, " code kept"}, code, 10);
      chk(stb_cnt == sc, {tag, " no strobe"}, stb_cnt, sc);
      chk(pulses == pc, {tag, " no acknowledge"}, pulses, pc);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      int sc;
      int pc;
      int exp_start;
      logic rfa;
      hold(1'b1, 10);
      rst_n = 1'b1;
      hold(1'b1, 20);

      // R1: reset state
      chk(code == 5'd31, "R1 code after reset", code, 31);
      chk(stb == 1'b0, "R1 strobe after reset", stb, 0);
      chk(pull == 1'b0, "R1 pull after reset", pull, 0);

      // R2 R7 R8 R11: every code, three bit-rate scales, both ack timing cases
      for (int c = 0; c < 32; c++) begin
         rfa = c[1];
         sc = stb_cnt;
         pc = pulses;
         send_bits({1'b0, 8'h72}, 8, 1 + (c % 3));
         send_bits({1'b0, rfa, 2'b00, 5'(c)}, 8, 1 + (c % 3));
         exp_start = last_fall + (((P_DLY + 1) > (last_lo + P_EOS + 2)) ?
                                  (P_DLY + 1) : (last_lo + P_EOS + 2));
         hold(1'b1, 250);
         chk(code == 5'(c), "R2 R11 decoded code", code, c);
         chk(stb_cnt == sc + 1, "R7 one strobe per command", stb_cnt, sc + 1);
         chk(pulses == pc + int'(rfa), "R8 acknowledge only on request", pulses, pc + int'(rfa));
         if (rfa) begin
            chk((pull_start >= exp_start - 2) && (pull_start <= exp_start + 2),
                "R8 acknowledge start", pull_start, exp_start);
            chk(last_len == P_LEN, "R8 acknowledge length", last_len, P_LEN);
         end
      end

      send_frame(8'h72, 8'h0A, 1);
      chk(code == 5'd10, "R7 set code 10", code, 10);

      // R6: each single-bit corruption of the address
      for (int i = 0; i < 8; i++) begin
         sc = stb_cnt; pc = pulses;
         send_frame(8'h72 ^ (8'h01 << i), 8'h83, 1);
         expect_no_change("R6", sc, pc);
      end

      // R7: nonzero select bits
      for (int a = 1; a < 4; a++) begin
         sc = stb_cnt; pc = pulses;
         send_frame(8'h72, {1'b1, 2'(a), 5'd3}, 1);
         expect_no_change("R7", sc, pc);
      end

      // R3: ratio misses the margin (low 8, high 6)
      sc = stb_cnt; pc = pulses;
      send_bits({1'b0, 8'h72}, 8, 1);
      hold(1'b0, 8); hold(1'b1, 6);
      send_bits(9'h003, 7, 1);
      hold(1'b1, 250);
      expect_no_change("R3", sc, pc);

      // R5: seven-bit data byte
      sc = stb_cnt; pc = pulses;
      send_bits({1'b0, 8'h72}, 8, 1);
      send_bits(9'h003, 7, 1);
      hold(1'b1, 250);
      expect_no_change("R5 short byte", sc, pc);

      // R5: nine-bit data byte
      sc = stb_cnt; pc = pulses;
      send_bits({1'b0, 8'h72}, 8, 1);
      send_bits(9'h007, 9, 1);
      hold(1'b1, 250);
      expect_no_change("R5 long byte", sc, pc);

      // R9: low phase beyond its limit
      sc = stb_cnt; pc = pulses;
      send_bits({1'b0, 8'h72}, 8, 1);
      hold(1'b0, P_LOW + 50);
      hold(1'b1, 60);
      send_bits(9'h083, 8, 1);
      hold(1'b1, 250);
      expect_no_change("R9 long low", sc, pc);

      // R9: gap between the bytes beyond its limit
      sc = stb_cnt; pc = pulses;
      send_bits({1'b0, 8'h72}, 8, 1);
      hold(1'b1, P_GAP + 50);
      send_bits(9'h083, 8, 1);
      hold(1'b1, 250);
      expect_no_change("R9 long gap", sc, pc);

      // R4 R10: shutdown-length low, then a start too short
      sc = stb_cnt; pc = pulses;
      hold(1'b0, 600);
      hold(1'b1, P_START - 4);
      send_bits({1'b0, 8'h72}, 8, 1);
      send_bits(9'h083, 8, 1);
      hold(1'b1, 250);
      expect_no_change("R4 R10 short start", sc, pc);

      // R4: start just long enough after a long low
      hold(1'b0, 600);
      hold(1'b1, P_START + 2);
      send_frame(8'h72, 8'h05, 2);
      chk(code == 5'd5, "R4 valid start accepted", code, 5);
      chk(pull == 1'b0, "R8 line released at end", pull, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule